// File: doc/BRIEF.md
# Interval Timer and Edge Counter with Interrupt

This peripheral holds one 16-bit up-counter that either advances on every clock (interval timer) or advances once per low-to-high transition of an external input (event counter). When it steps past its all-ones value, it reloads a preset taken from a parameter, so it overflows again after a fixed number of ticks. With the default preset of 0xFFC0, that is every 64 ticks. Each overflow sets a sticky interrupt flag. An interrupt request output follows that flag whenever software has enabled interrupts.

Software reaches the block over a plain memory-mapped bus with a select, a read strobe, a write strobe, a one-bit register address and a shared bidirectional data bus. Address 0 is the control register, which holds the mode, the interrupt enable and a run bit. Address 1 is the status register, which holds the flag. The peripheral never stalls the bus, and it leaves the data lines floating unless it is being read.

Top module: `tmr_top`

## Requirements
- R1: After reset, the control and status registers read 0x0000, `irq` is 0, and the counter holds the preset value.
- R2: In timer mode with run set (control value 0x0007 or 0x0005), the flag sets on exactly the 64th clock edge after the edge that wrote the control register. This count holds for the default preset 0xFFC0.
- R3: On overflow the counter reloads the preset, so the next overflow follows exactly 64 further ticks.
- R4: In counter mode (control bit 0 = 0, run = 1), the counter advances once per 0-to-1 change of `ext_in`. A held high level counts once. No change counts nothing.
- R5: While run (control bit 2) is 0, the count is held and no flag is set. When run returns to 1, counting resumes from the held value.
- R6: The flag sets on overflow whatever the interrupt enable is. `irq` equals the flag AND control bit 1.
- R7: A write of 0 to status bit 0 clears the flag, and a write of 1 leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R8: Control reads as {13'b0, run, irq_en, timer_mode} (bits 2,1,0). Status reads as {15'b0, flag}.
- R9: The block drives `bus_data` only while `sel` and `rd_en` are both 1. At all other times the lines are high-impedance.
- R10: `ready` equals `sel` in the same cycle, so no access ever waits.
- R11: A write strobe with `sel` at 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Peripheral select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| reg_addr | input | 1 | 0 = control, 1 = status |
| bus_data | inout | 16 | Shared data bus: write data in, read data out |
| ready | output | 1 | Access complete |
| ext_in | input | 1 | Event input counted in counter mode |
| irq | output | 1 | Interrupt request |

## Verification
The count itself never appears at the ports. A wrong count, a missed reload or a tick taken while stopped therefore shows up only as the interrupt arriving on the wrong edge. The bench times that edge to the exact cycle, and a single extra or missing tick moves the flag by one clock. An edge detector that counts levels instead of transitions overflows far too early under a long high pulse, and this is visible as an early `irq`. A bad read path shows at once, in the same cycle, as a wrong value or as contention on a bus that the bench holds at zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Control register layout: bit 2 run, bit 1 irq enable, bit 0 timer mode
  typedef struct packed {
    logic run;
    logic irq_en;
    logic timer_mode;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic smp_q;
  logic old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      old_q <= 1'b0;
    end else begin
      smp_q <= sig_i;
      old_q <= smp_q;
    end
  end

  // one-cycle pulse per 0-to-1 change of the sampled input
  assign rise_o = smp_q & ~old_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned    CNT_W    = 16,
  parameter logic [CNT_W-1:0] INIT_VAL = 16'hFFC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             timer_mode_i,
  input  logic             rise_i,
  output logic             tick_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;

  assign tick_o = run_i & (timer_mode_i | rise_i);
  assign at_max = (cnt_q == CNT_MAX);
  assign ovf_o  = tick_o & at_max;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_o) begin
      if (at_max) cnt_d = INIT_VAL;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_VAL;
    else if (tick_o) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ovf_i,
  output tmr_ctrl_t         ctrl_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              rd_drv_o,
  output logic [DATA_W-1:0] rdata_o
);

  tmr_ctrl_t ctrl_q;
  tmr_ctrl_t ctrl_d;
  logic      ctrl_we;
  logic      flag_q;
  logic      flag_d;
  logic      stat_clr;

  assign ctrl_we  = sel_i & wr_en_i & (addr_i == ADDR_CTRL);
  assign stat_clr = sel_i & wr_en_i & (addr_i == ADDR_STAT) & ~wdata_i[0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = tmr_ctrl_t'(wdata_i);
  end

  // overflow takes priority over a software clear
  always_comb begin
    flag_d = flag_q;
    if (stat_clr) flag_d = 1'b0;
    if (ovf_i)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_we)         ctrl_q <= ctrl_d;
      if (stat_clr | ovf_i) flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) rdata_o[CTRL_W-1:0] = ctrl_q;
    else                     rdata_o[0]          = flag_q;
  end

  assign rd_drv_o = sel_i & rd_en_i;
  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int unsigned      DATA_W   = 16,
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] INIT_VAL = 16'hFFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              reg_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              ready,
  input  logic              ext_in,
  output logic              irq
);

  tmr_ctrl_t          ctrl_q;
  logic               ext_rise;
  logic               cnt_tick;
  logic               cnt_ovf;
  logic [CNT_W-1:0]   cnt_val;
  logic               irq_flag;
  logic               rd_drv;
  logic [DATA_W-1:0]  rd_val;

  tmr_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (ext_in),
    .rise_o (ext_rise)
  );

  tmr_count_core #(
    .CNT_W    (CNT_W),
    .INIT_VAL (INIT_VAL)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ctrl_q.run),
    .timer_mode_i (ctrl_q.timer_mode),
    .rise_i       (ext_rise),
    .tick_o       (cnt_tick),
    .ovf_o        (cnt_ovf),
    .cnt_o        (cnt_val)
  );

  tmr_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel),
    .rd_en_i  (rd_en),
    .wr_en_i  (wr_en),
    .addr_i   (reg_addr),
    .wdata_i  (bus_data[CTRL_W-1:0]),
    .ovf_i    (cnt_ovf),
    .ctrl_o   (ctrl_q),
    .flag_o   (irq_flag),
    .irq_o    (irq),
    .rd_drv_o (rd_drv),
    .rdata_o  (rd_val)
  );

  assign bus_data = rd_drv ? rd_val : {DATA_W{1'bz}};
  assign ready    = sel;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] INIT_VAL = 16'hFFC0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt,
  input tmr_ctrl_t        ctrl,
  input logic             rise,
  input logic             flag
);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == INIT_VAL));

  // R5
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> $stable(cnt));

  // R4
  no_edge_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.timer_mode && !rise) |=> $stable(cnt));

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ovf));

endmodule

bind tmr_top tmr_chk #(
  .CNT_W    (CNT_W),
  .INIT_VAL (INIT_VAL)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (cnt_tick),
  .ovf   (cnt_ovf),
  .cnt   (cnt_val),
  .ctrl  (ctrl_q),
  .rise  (ext_rise),
  .flag  (irq_flag)
);

// File: tb/tb_tmr_top.sv
`timescale 1ns/1ps
module tb_tmr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        reg_addr = 1'b0;
  logic        ext_in = 1'b0;
  logic        tb_oe = 1'b0;
  logic [15:0] tb_drv = 16'h0000;
  wire  [15:0] bus_w;
  wire         ready;
  wire         irq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string       req;
    logic [15:0] exp;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  assign bus_w = tb_oe ? tb_drv : 16'hzzzz;

  tmr_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .bus_data (bus_w),
    .ready    (ready),
    .ext_in   (ext_in),
    .irq      (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares each read cycle against the next scoreboard entry
  always @(negedge clk) begin
    exp_t e;
    if (sel && rd_en && !tb_oe) begin
      if (sb_q.size() == 0) begin
        check("scoreboard underflow", 16'h0001, 16'h0000);
      end else begin
        e = sb_q.pop_front();
        check(e.req, bus_w, e.exp);
      end
    end
  end

  task automatic rd(input logic a, input logic [15:0] exp, input string req);
    @(posedge clk); #1;
    sel = 1'b1; rd_en = 1'b1; reg_addr = a;
    sb_q.push_back('{req, exp});
    @(posedge clk); #1;
    sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wr_en = 1'b1; reg_addr = a; tb_oe = 1'b1; tb_drv = d;
    @(posedge clk); #1;
    sel = 1'b0; wr_en = 1'b0; tb_oe = 1'b0;
  endtask

  task automatic do_reset();
    ext_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(posedge clk); #1 ext_in = 1'b1;
    repeat (hi) @(posedge clk);
    #1 ext_in = 1'b0;
    repeat (lo) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state, R10 ready
    do_reset();
    check("R1 irq after reset", {15'b0, irq}, 16'h0000);
    check("R10 ready idle", {15'b0, ready}, 16'h0000);
    rd(1'b0, 16'h0000, "R1 control after reset");
    rd(1'b1, 16'h0000, "R1 status after reset");
    @(posedge clk); #1 sel = 1'b1;
    check("R10 ready with sel", {15'b0, ready}, 16'h0001);
    sel = 1'b0;

    // R2 timer period, R3 reload, R7 clear rules
    wr(1'b0, 16'h0007);
    repeat (63) @(posedge clk); #1;
    check("R2 no flag before 64 ticks", {15'b0, irq}, 16'h0000);
    @(posedge clk); #1;
    check("R2 flag at 64th tick", {15'b0, irq}, 16'h0001);
    wr(1'b1, 16'h0000);
    check("R7 clear by writing 0", {15'b0, irq}, 16'h0000);
    repeat (61) @(posedge clk); #1;
    check("R3 no flag before reload period", {15'b0, irq}, 16'h0000);
    @(posedge clk); #1;
    check("R3 flag after reload period", {15'b0, irq}, 16'h0001);
    wr(1'b1, 16'h0000);
    check("R7 clear again", {15'b0, irq}, 16'h0000);
    repeat (60) @(posedge clk);
    wr(1'b1, 16'h0000);
    check("R7 overflow beats clear", {15'b0, irq}, 16'h0001);
    wr(1'b1, 16'h0000);
    wr(1'b1, 16'h0001);
    check("R7 writing 1 does not set", {15'b0, irq}, 16'h0000);
    rd(1'b0, 16'h0007, "R8 control readback");
    rd(1'b1, 16'h0000, "R8 status readback");

    // R6 flag independent of enable
    do_reset();
    wr(1'b0, 16'h0005);
    repeat (64) @(posedge clk); #1;
    check("R6 irq masked", {15'b0, irq}, 16'h0000);
    rd(1'b1, 16'h0001, "R6 flag set while masked");
    wr(1'b0, 16'h0007);
    check("R6 irq on enable", {15'b0, irq}, 16'h0001);

    // R5 stop holds count
    do_reset();
    wr(1'b0, 16'h0007);
    repeat (30) @(posedge clk);
    wr(1'b0, 16'h0003);
    repeat (100) @(posedge clk); #1;
    check("R5 no flag while stopped", {15'b0, irq}, 16'h0000);
    rd(1'b1, 16'h0000, "R5 status while stopped");
    wr(1'b0, 16'h0007);
    repeat (31) @(posedge clk); #1;
    check("R5 resume not early", {15'b0, irq}, 16'h0000);
    @(posedge clk); #1;
    check("R5 resume from held count", {15'b0, irq}, 16'h0001);

    // R4 edge counting
    do_reset();
    wr(1'b0, 16'h0006);
    pulse(20, 3);
    for (int i = 0; i < 62; i++) pulse(2, 2);
    repeat (100) @(posedge clk); #1;
    check("R4 63 edges no flag", {15'b0, irq}, 16'h0000);
    pulse(2, 2); #1;
    check("R4 64th edge sets flag", {15'b0, irq}, 16'h0001);

    // R11 unselected write, R9 bus release
    do_reset();
    @(posedge clk); #1;
    wr_en = 1'b1; tb_oe = 1'b1; tb_drv = 16'h0007; reg_addr = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0; tb_oe = 1'b0;
    rd(1'b0, 16'h0000, "R11 unselected write ignored");
    wr(1'b0, 16'h0007);
    @(posedge clk); #1;
    sel = 1'b1; rd_en = 1'b0; tb_oe = 1'b1; tb_drv = 16'h0000;
    #2 check("R9 released with sel only", bus_w, 16'h0000);
    sel = 1'b0; rd_en = 1'b1;
    #2 check("R9 released with rd_en only", bus_w, 16'h0000);
    rd_en = 1'b0; tb_oe = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule